// File: doc/BRIEF.md
# Chained Serial Loader for Multi-Channel DAC Codes

This block is the digital front end of a multi-channel 6-bit digital-to-analog converter. A host holds an active-low select line low and clocks codes in on a serial data line, one bit per falling edge of a slow serial clock. Each code is six bits, sent high bit first. The bits travel through one long shift chain made of one 6-bit stage per channel. When the select line returns high, the whole chain is copied into the per-channel holding registers in a single step. Each holding register drives the 6-bit code of its channel toward the analog converter.

The far end of the chain is brought out as a serial output. That output can feed the serial data input of a second block that shares the same serial clock and select line, so several blocks can be loaded as one long chain. The word clocked in last always goes to channel 1. A short transfer of k words therefore refreshes channels 1 to k. While the select line is high, the serial clock is held off the chain by a level-sensitive gate.

All three serial inputs are sampled by the system clock `clk` and are assumed to be synchronous to it. Edges of the serial clock and of the select line are detected from these samples.

Top module: `sdac_top`

## Requirements
- R1: While `rstN` is low and after its release, every channel code reads 0 and `serDout` reads 0, until shifting or a load changes them.
- R2: A falling edge of `serClk` seen with `selN` low shifts the chain on the second rising edge of `clk` after the edge is presented at the ports. `serDout` changes in that cycle and in no other cycle.
- R3: Codes enter high bit first. Bit 5 of a channel's code is the first bit shifted in for that word. After a full transfer of `CH_COUNT` words and a load, channel 1 (bits [5:0] of `chCodes`) holds the last word, channel 2 (bits [11:6]) holds the word before it, and so on up to channel `CH_COUNT`.
- R4: A rising edge of `selN` copies the chain into the holding registers. The new codes appear on the second rising edge of `clk` after the edge is presented, and not before.
- R5: The channel codes do not change while `selN` stays low, nor at any time other than the load of R4.
- R6: A transfer of k words followed by a load sets channels 1 to k to those words. Each higher channel receives the content that sat k stages below it in the chain.
- R7: `serDout` carries the bit shifted in `6*CH_COUNT` shifts earlier, which is 0 after reset. A second block whose serial input is driven by `serDout`, sharing `serClk` and `selN`, receives the words that fall out of the first block.
- R8: While `selN` is high, edges of `serClk` do not move the chain.
- R9: The gate behaves as a transparent latch. Suppose the serial clock is high when `selN` rises and is low when `selN` falls again. Then that fall of `selN` counts as one falling edge of the serial clock and shifts one bit.
- R10: If `selN` rises in the same sample as a falling edge of `serClk`, the edge is blocked and the load takes the chain as it was before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial inputs |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial shift clock; the chain shifts on its falling edge |
| serDin | input | 1 | Serial data input, high bit of each word first |
| selN | input | 1 | Active-low select; its rising edge loads the holding registers |
| serDout | output | 1 | Far end of the shift chain, for chaining blocks |
| chCodes | output | 6*CH_COUNT | Channel codes; channel 1 in bits [5:0], channel n in bits [6n-1:6n-6] |

## Verification
The two functions that can fall in the same cycle are the shifting of the chain and the copy into the holding registers. This happens when the select line rises in the very sample in which the serial clock falls. The bench drives both edges on the same system-clock edge, once directly and once in the latch case where the select line rises and falls around a serial clock transition. It then judges the outcome from the channel codes: these show whether the clock edge was blocked, and the following word shows whether a deferred edge shifted exactly one bit. A behavioural queue model compares every channel code and the serial output on every clock.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  // Strobes from control to datapath, valid for one clk cycle.
  typedef struct packed {
    logic shift;  // advance the chain by one bit
    logic load;   // copy the chain into the holding registers
    logic din;    // bit to insert on shift
  } sdac_strobe_t;

endpackage

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
  import sdac_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         serClk,
  input  logic         serDin,
  input  logic         selN,
  output sdac_strobe_t strb
);

  logic serClkQ;
  logic selNQ;
  logic selNPrevQ;
  logic dinQ;
  logic gateQ;      // output of the level-sensitive gate on the serial clock
  logic gateNext;

  // Sample the serial inputs once on clk.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serClkQ   <= 1'b0;
      selNQ     <= 1'b1;
      selNPrevQ <= 1'b1;
      dinQ      <= 1'b0;
    end else begin
      serClkQ   <= serClk;
      selNQ     <= selN;
      selNPrevQ <= selNQ;
      dinQ      <= serDin;
    end
  end

  // The gate is transparent while select is low and holds otherwise.
  always_comb begin
    gateNext = selNQ ? gateQ : serClkQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gateQ <= 1'b0;
    else       gateQ <= gateNext;
  end

  always_comb begin
    strb.shift = gateQ & ~gateNext;
    strb.load  = selNQ & ~selNPrevQ;
    strb.din   = dinQ;
  end

  // R10
  noCollide_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.shift && strb.load));

  // R8
  blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(selN) |-> !strb.shift);

  // R4
  loadEdge_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> $past(selN));

endmodule

// File: rtl/sdac_datapath.sv
module sdac_datapath
  import sdac_pkg::*;
#(
  parameter int CH_COUNT = 6,
  parameter int CODE_W   = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  sdac_strobe_t                 strb,
  output logic                         serDout,
  output logic [CH_COUNT*CODE_W-1:0]   chCodes
);

  localparam int CHAIN_W = CH_COUNT * CODE_W;

  // Newest bit at bit 0; channel 1 occupies the lowest stage.
  logic [CHAIN_W-1:0] chainQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           chainQ <= '0;
    else if (strb.shift) chainQ <= {chainQ[CHAIN_W-2:0], strb.din};
  end

  assign serDout = chainQ[CHAIN_W-1];

  for (genvar g = 0; g < CH_COUNT; g++) begin : gHold
    logic [CODE_W-1:0] holdQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          holdQ <= '0;
      else if (strb.load) holdQ <= chainQ[g*CODE_W +: CODE_W];
    end
    assign chCodes[g*CODE_W +: CODE_W] = holdQ;
  end

  // R5
  holdStable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(chCodes));

  // R2
  doutStable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shift |=> $stable(serDout));

endmodule

// File: rtl/sdac_top.sv
module sdac_top
  import sdac_pkg::*;
#(
  parameter int CH_COUNT = 6,
  parameter int CODE_W   = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       serClk,
  input  logic                       serDin,
  input  logic                       selN,
  output logic                       serDout,
  output logic [CH_COUNT*CODE_W-1:0] chCodes
);

  sdac_strobe_t strb;

  sdac_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .serClk (serClk),
    .serDin (serDin),
    .selN   (selN),
    .strb   (strb)
  );

  sdac_datapath #(
    .CH_COUNT (CH_COUNT),
    .CODE_W   (CODE_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .serDout (serDout),
    .chCodes (chCodes)
  );

endmodule

// File: tb/sdac_top_tb.sv
module sdac_top_tb;

  localparam int CH  = 6;
  localparam int W   = 6;
  localparam int CHW = CH * W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0;
  logic serDin = 1'b0;
  logic selN = 1'b1;
  logic serDout, nextDout;
  logic [CHW-1:0] chCodes, nextCodes;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sdac_top #(.CH_COUNT(CH), .CODE_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serDin(serDin), .selN(selN),
    .serDout(serDout), .chCodes(chCodes)
  );

  sdac_top #(.CH_COUNT(CH), .CODE_W(W)) u_next (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serDin(serDout), .selN(selN),
    .serDout(nextDout), .chCodes(nextCodes)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: a queue of bits, newest at index 0.
  bit mSer, mSel, mDin, mGate, mSelPrev, mSh, mLd;
  bit q[$];
  logic [W-1:0] mHold [CH];

  always @(posedge clk) begin
    if (!rstN) begin
      mSer = 0; mSel = 1; mDin = 0; mGate = 0; mSelPrev = 1;
      q = {};
      for (int i = 0; i < CHW; i++) q.push_back(1'b0);
      for (int k = 0; k < CH; k++) mHold[k] = '0;
    end else begin
      mSh = mGate && !mSel && !mSer;
      mLd = mSel && !mSelPrev;
      if (mLd)
        for (int k = 0; k < CH; k++)
          for (int j = 0; j < W; j++) mHold[k][j] = q[k*W + j];
      if (mSh) begin
        q.push_front(mDin);
        void'(q.pop_back());
      end
      if (!mSel) mGate = mSer;
      mSelPrev = mSel;
      mSer = serClk; mSel = selN; mDin = serDin;
    end
  end

  // Compare on every falling clk edge, away from the updating edge.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R2 serDout vs model", serDout, q[CHW-1]);
      for (int k = 0; k < CH; k++)
        chk("R4 channel vs model", chCodes[k*W +: W], mHold[k]);
    end
  end

  function automatic logic [W-1:0] code(input int k);
    return ch_slice(chCodes, k);
  endfunction

  function automatic logic [W-1:0] ch_slice(input logic [CHW-1:0] v, input int k);
    return v[(k-1)*W +: W];
  endfunction

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclkBit(input logic b);
    @(negedge clk); serDin = b; serClk = 1'b1;
    waitN(2);
    serClk = 1'b0;
    waitN(2);
  endtask

  task automatic sendWord(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) sclkBit(w[i]);
  endtask

  task automatic selLow();
    @(negedge clk); selN = 1'b0;
    waitN(2);
  endtask

  task automatic selHigh();
    @(negedge clk); selN = 1'b1;
    waitN(3);
  endtask

  function automatic logic [W-1:0] wordA(input int i);
    return W'((i * 13 + 7) % 64);
  endfunction

  function automatic logic [W-1:0] wordB(input int i);
    return W'((i * 29 + 5) % 64);
  endfunction

  initial begin : watchdog
    #3_000_000;
    if (!finished) begin
      nChecks++; nErr++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] a, b, c;
    a = 6'h2D; b = 6'h13; c = 6'h36;
    waitN(3);
    // R1 reset state
    chk("R1 codes in reset", chCodes, '0);
    chk("R1 serDout in reset", serDout, 1'b0);
    @(negedge clk); rstN = 1'b1;
    waitN(2);
    chk("R1 codes after reset", chCodes, '0);

    // R3 full transfer, R5 no change while select low
    selLow();
    for (int i = 0; i < CH; i++) sendWord(wordA(i));
    chk("R5 codes held while select low", chCodes, '0);
    @(negedge clk); selN = 1'b1;
    @(negedge clk);
    chk("R4 no update one clk after select rise", chCodes, '0);
    @(negedge clk);
    for (int k = 1; k <= CH; k++)
      chk("R3 channel order", code(k), wordA(CH - k));
    waitN(1);

    // R6 partial transfer of two words
    selLow();
    sendWord(a); sendWord(b);
    selHigh();
    chk("R6 ch1 last word", code(1), b);
    chk("R6 ch2 prior word", code(2), a);
    chk("R6 ch3 shifted old ch1", code(3), wordA(CH - 1));

    // R8 serial clock ignored while select high
    for (int i = 0; i < W; i++) sclkBit(i[0]);
    chk("R8 codes after blocked clocks", code(1), b);
    selLow();
    sendWord(c);
    selHigh();
    chk("R8 ch1 new word", code(1), c);
    chk("R8 ch2 no extra shift", code(2), b);
    chk("R8 ch3 no extra shift", code(3), a);

    // R9 latch: clock high at select rise, low at select fall
    selLow();
    @(negedge clk); serClk = 1'b1; waitN(2);
    @(negedge clk); selN = 1'b1; waitN(2);
    @(negedge clk); serClk = 1'b0; waitN(2);
    @(negedge clk); serDin = 1'b1; selN = 1'b0; waitN(3);
    sclkBit(1'b0); sclkBit(1'b1); sclkBit(1'b0); sclkBit(1'b1); sclkBit(1'b0);
    selHigh();
    chk("R9 deferred edge shifted one bit", code(1), 6'b101010);
    chk("R9 ch2", code(2), c);

    // R10 select rise together with serial clock fall
    selLow();
    for (int i = 0; i < W - 1; i++) sclkBit(1'b1);
    @(negedge clk); serDin = 1'b1; serClk = 1'b1; waitN(2);
    @(negedge clk); serClk = 1'b0; selN = 1'b1; waitN(3);
    chk("R10 blocked edge, load of prior chain", code(1), 6'b011111);
    waitN(2);

    // R7 cascade of two blocks
    selLow();
    for (int i = 0; i < 2 * CH; i++) sendWord(wordB(i));
    selHigh();
    for (int k = 1; k <= CH; k++) begin
      chk("R7 first block channel", code(k), wordB(2 * CH - k));
      chk("R7 second block channel", ch_slice(nextCodes, k), wordB(CH - k));
    end
    chk("R7 serDout bit that falls next", serDout, wordB(CH)[W-1]);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule